// File: doc/BRIEF.md
# Single-Outstanding DMA Request Bridge

This block connects a DMA sequencer to a memory-side directory. Load and store requests arrive on a request channel with a valid/ready handshake. Each legal request is captured in a one-entry transaction buffer and turned into a read or write message toward the directory. That message appears on the directory port a fixed, parameterised number of cycles after it is accepted, and it is held there until the directory takes it.

Only one transaction is ever in flight. While the bridge waits for the answer, it withdraws ready on the request channel, so the next request waits in the sender's queue and is neither lost nor refused. Responses come back on their own channel. A data response on a pending read, or an acknowledge on a pending write, is returned to the sequencer as a one-cycle strobe together with the line address of the transaction. The bridge is then free again.

Request or response codes that are not legal, and responses that do not match the current transaction, are discarded. They set an error flag that stays set until reset.

Top module: `dma_req_bridge`

## Requirements
- R1: After reset the bridge is idle: `rq_ready` is 1, and `dir_valid`, `seq_data_vld`, `seq_ack_vld` and `err_flag` are all 0.
- R2: A load request (`rq_kind` = 2'b01) accepted while idle produces a read message (`dir_is_wr` = 0). The message carries the physical address, line address, data block and length copied from the request, and `dir_rqid` equal to the `REQ_ID` parameter.
- R3: A store request (`rq_kind` = 2'b10) accepted while idle produces a write message (`dir_is_wr` = 1) with the same copied fields.
- R4: If the request handshake completes on clock edge n, `dir_valid` is first high after edge n+`ISSUE_DLY`, and it is low before that.
- R5: While `dir_valid` is high and `dir_ready` is low, every directory field stays unchanged. `dir_valid` falls after the edge on which `dir_ready` is sampled high.
- R6: From the edge that accepts a legal request until the edge that accepts its matching response, `rq_ready` is 0. A request held on the channel during that time is accepted on the first edge after the bridge is idle again.
- R7: A data response (`rs_kind` = 2'b01) accepted while a read is pending stores `rs_data` in the entry. For exactly one cycle after that edge it raises `seq_data_vld`, with `seq_data` equal to the returned block and `seq_laddr` equal to the request's line address, and the bridge is idle again.
- R8: An acknowledge response (`rs_kind` = 2'b10) accepted while a write is pending raises `seq_ack_vld` for exactly one cycle, with `seq_laddr` equal to the request's line address, and the bridge is idle again.
- R9: `rs_ready` is 0 while an issued message has not yet been taken by the directory, and 1 otherwise.
- R10: A request with code 2'b00 or 2'b11 accepted while idle is consumed and sets `err_flag`. It produces no directory message, and the bridge stays idle.
- R11: A response with code 2'b00 or 2'b11, a data response while not reading, or an acknowledge while not writing is consumed and sets `err_flag`. It raises no strobe and leaves the pending transaction unchanged.
- R12: Once set, `err_flag` stays 1 through later traffic until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rq_valid | input | 1 | Request present |
| rq_ready | output | 1 | Bridge can take a request |
| rq_kind | input | 2 | Request code: 01 load, 10 store |
| rq_paddr | input | ADDR_W | Physical address |
| rq_laddr | input | ADDR_W | Line address |
| rq_data | input | BLK_W | Data block |
| rq_len | input | LEN_W | Byte length |
| rs_valid | input | 1 | Response present |
| rs_ready | output | 1 | Bridge can take a response |
| rs_kind | input | 2 | Response code: 01 data, 10 acknowledge |
| rs_data | input | BLK_W | Returned block |
| dir_valid | output | 1 | Message to directory valid |
| dir_ready | input | 1 | Directory takes message |
| dir_is_wr | output | 1 | 1 write, 0 read |
| dir_paddr | output | ADDR_W | Physical address |
| dir_laddr | output | ADDR_W | Line address |
| dir_rqid | output | ID_W | Requester identity |
| dir_data | output | BLK_W | Data block |
| dir_len | output | LEN_W | Byte length |
| seq_data_vld | output | 1 | Read data strobe |
| seq_ack_vld | output | 1 | Write acknowledge strobe |
| seq_laddr | output | ADDR_W | Line address of completed transaction |
| seq_data | output | BLK_W | Returned block |
| err_flag | output | 1 | Sticky protocol error |

## Verification
The bench keeps a store waiting on the request channel while a read is in flight. A bridge that did not stall would issue a second message or overwrite the entry. A bridge that did not pick the held request up again would hang. The bench sends a data response during a pending write and while idle. A bridge that failed to check the state would raise a false data strobe or end the write early. It counts the cycles from acceptance to `dir_valid` exactly, which catches off-by-one errors in the delay. It holds `dir_ready` low to show that the fields stay still and that responses are refused until the message has left.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
   typedef enum logic [1:0] {
      ST_READY   = 2'd0,
      ST_BUSY_RD = 2'd1,
      ST_BUSY_WR = 2'd2
   } dmab_state_e;

   localparam logic [1:0] RQ_LOAD  = 2'b01;
   localparam logic [1:0] RQ_STORE = 2'b10;
   localparam logic [1:0] RS_DATA  = 2'b01;
   localparam logic [1:0] RS_ACK   = 2'b10;
endpackage

// File: rtl/dmab_ctrl.sv
module dmab_ctrl
   import dmab_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rq_valid,
   input  logic [1:0]  rq_kind,
   input  logic        rs_valid,
   input  logic [1:0]  rs_kind,
   input  logic        rs_ready,
   output dmab_state_e state,
   output logic        rq_ready,
   output logic        take_load,
   output logic        take_store,
   output logic        done_rd,
   output logic        done_wr,
   output logic        err_flag
);
   dmab_state_e st_q, st_d;
   logic        rq_fire, rs_fire, bad_rq, bad_rs, err_q;

   assign rq_ready   = (st_q == ST_READY);
   assign rq_fire    = rq_valid && rq_ready;
   assign take_load  = rq_fire && (rq_kind == RQ_LOAD);
   assign take_store = rq_fire && (rq_kind == RQ_STORE);
   assign bad_rq     = rq_fire && !take_load && !take_store;

   assign rs_fire = rs_valid && rs_ready;
   assign done_rd = rs_fire && (st_q == ST_BUSY_RD) && (rs_kind == RS_DATA);
   assign done_wr = rs_fire && (st_q == ST_BUSY_WR) && (rs_kind == RS_ACK);
   assign bad_rs  = rs_fire && !done_rd && !done_wr;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_READY: begin
            if (take_load)       st_d = ST_BUSY_RD;
            else if (take_store) st_d = ST_BUSY_WR;
         end
         ST_BUSY_RD: if (done_rd) st_d = ST_READY;
         ST_BUSY_WR: if (done_wr) st_d = ST_READY;
         default: st_d = ST_READY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_READY;
         err_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (bad_rq || bad_rs) err_q <= 1'b1;
      end
   end

   assign state    = st_q;
   assign err_flag = err_q;
endmodule

// File: rtl/dmab_entry.sv
module dmab_entry #(
   parameter int ADDR_W = 48,
   parameter int BLK_W  = 512,
   parameter int LEN_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              is_wr_in,
   input  logic [ADDR_W-1:0] paddr_in,
   input  logic [ADDR_W-1:0] laddr_in,
   input  logic [BLK_W-1:0]  data_in,
   input  logic [LEN_W-1:0]  len_in,
   input  logic              fill_en,
   input  logic [BLK_W-1:0]  fill_data,
   output logic              is_wr,
   output logic [ADDR_W-1:0] paddr,
   output logic [ADDR_W-1:0] laddr,
   output logic [BLK_W-1:0]  data,
   output logic [LEN_W-1:0]  len
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_wr <= 1'b0;
         paddr <= '0;
         laddr <= '0;
         data  <= '0;
         len   <= '0;
      end else if (load_en) begin
         is_wr <= is_wr_in;
         paddr <= paddr_in;
         laddr <= laddr_in;
         data  <= data_in;
         len   <= len_in;
      end else if (fill_en) begin
         data <= fill_data;
      end
   end
endmodule

// File: rtl/dmab_issue.sv
module dmab_issue #(
   parameter int DLY = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic out_ready,
   output logic out_valid,
   output logic pending
);
   logic pend_q, ripe;

   generate
      if (DLY > 0) begin : g_timed
         localparam int CNT_W = $clog2(DLY + 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (launch)          cnt_q <= CNT_W'(DLY);
            else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
         end
         assign ripe = (cnt_q == '0);
      end else begin : g_direct
         assign ripe = 1'b1;
      end
   endgenerate

   assign out_valid = pend_q && ripe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pend_q <= 1'b0;
      else if (launch)                 pend_q <= 1'b1;
      else if (out_valid && out_ready) pend_q <= 1'b0;
   end

   assign pending = pend_q;
endmodule

// File: rtl/dma_req_bridge.sv
module dma_req_bridge
   import dmab_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int BLK_W     = 512,
   parameter int ID_W      = 4,
   parameter int REQ_ID    = 0,
   parameter int ISSUE_DLY = 6,
   localparam int LEN_W    = $clog2(BLK_W / 8) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rq_valid,
   output logic              rq_ready,
   input  logic [1:0]        rq_kind,
   input  logic [ADDR_W-1:0] rq_paddr,
   input  logic [ADDR_W-1:0] rq_laddr,
   input  logic [BLK_W-1:0]  rq_data,
   input  logic [LEN_W-1:0]  rq_len,
   input  logic              rs_valid,
   output logic              rs_ready,
   input  logic [1:0]        rs_kind,
   input  logic [BLK_W-1:0]  rs_data,
   output logic              dir_valid,
   input  logic              dir_ready,
   output logic              dir_is_wr,
   output logic [ADDR_W-1:0] dir_paddr,
   output logic [ADDR_W-1:0] dir_laddr,
   output logic [ID_W-1:0]   dir_rqid,
   output logic [BLK_W-1:0]  dir_data,
   output logic [LEN_W-1:0]  dir_len,
   output logic              seq_data_vld,
   output logic              seq_ack_vld,
   output logic [ADDR_W-1:0] seq_laddr,
   output logic [BLK_W-1:0]  seq_data,
   output logic              err_flag
);
   generate
      if (ADDR_W < 1)            begin : g_bad_addr $error("ADDR_W must be positive"); end
      if (BLK_W < 8 || BLK_W % 8 != 0) begin : g_bad_blk $error("BLK_W must be whole bytes"); end
      if (ID_W < 1)              begin : g_bad_id   $error("ID_W must be positive"); end
      if (REQ_ID < 0 || REQ_ID >= (1 << ID_W)) begin : g_bad_rqid $error("REQ_ID does not fit ID_W"); end
      if (ISSUE_DLY < 0)         begin : g_bad_dly  $error("ISSUE_DLY must not be negative"); end
   endgenerate

   dmab_state_e st;
   logic take_load, take_store, done_rd, done_wr, pend;
   logic dv_q, av_q;

   dmab_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .rq_valid(rq_valid), .rq_kind(rq_kind),
      .rs_valid(rs_valid), .rs_kind(rs_kind), .rs_ready(rs_ready),
      .state(st), .rq_ready(rq_ready),
      .take_load(take_load), .take_store(take_store),
      .done_rd(done_rd), .done_wr(done_wr), .err_flag(err_flag)
   );

   dmab_entry #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .LEN_W(LEN_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .load_en(take_load || take_store), .is_wr_in(take_store),
      .paddr_in(rq_paddr), .laddr_in(rq_laddr), .data_in(rq_data), .len_in(rq_len),
      .fill_en(done_rd), .fill_data(rs_data),
      .is_wr(dir_is_wr), .paddr(dir_paddr), .laddr(dir_laddr),
      .data(dir_data), .len(dir_len)
   );

   dmab_issue #(.DLY(ISSUE_DLY)) u_issue (
      .clk(clk), .rst_n(rst_n),
      .launch(take_load || take_store), .out_ready(dir_ready),
      .out_valid(dir_valid), .pending(pend)
   );

   assign rs_ready = !pend;
   assign dir_rqid = ID_W'(REQ_ID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q <= 1'b0;
         av_q <= 1'b0;
      end else begin
         dv_q <= done_rd;
         av_q <= done_wr;
      end
   end

   assign seq_data_vld = dv_q;
   assign seq_ack_vld  = av_q;
   assign seq_laddr    = dir_laddr;
   assign seq_data     = dir_data;
endmodule

// File: rtl/dmab_checker.sv
module dmab_checker
   import dmab_pkg::*;
#(
   parameter int ADDR_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rq_valid,
   input logic              rq_ready,
   input logic [1:0]        rq_kind,
   input logic              dir_valid,
   input logic              dir_ready,
   input logic              dir_is_wr,
   input logic [ADDR_W-1:0] dir_laddr,
   input logic              seq_data_vld,
   input logic              seq_ack_vld,
   input logic              err_flag,
   input dmab_state_e       state
);
   assert_load_to_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && rq_ready && rq_kind == RQ_LOAD) |=> (state == ST_BUSY_RD && !rq_ready));

   assert_store_to_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid && rq_ready && rq_kind == RQ_STORE) |=> (state == ST_BUSY_WR && !rq_ready));

   assert_msg_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_valid && !dir_ready) |=> (dir_valid && $stable(dir_laddr) && $stable(dir_is_wr)));

   assert_single_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dir_valid |-> (state != ST_READY));

   assert_data_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_data_vld |-> ($past(state) == ST_BUSY_RD && state == ST_READY && !seq_ack_vld));

   assert_ack_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_ack_vld |-> ($past(state) == ST_BUSY_WR && state == ST_READY));

   assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);
endmodule

bind dma_req_bridge dmab_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_kind(rq_kind),
   .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_is_wr(dir_is_wr),
   .dir_laddr(dir_laddr), .seq_data_vld(seq_data_vld), .seq_ack_vld(seq_ack_vld),
   .err_flag(err_flag), .state(st)
);

// File: tb/sim_dma_req_bridge.sv
`timescale 1ns/1ps
module sim_dma_req_bridge;
   localparam int AW = 16;
   localparam int BW = 32;
   localparam int IW = 4;
   localparam int RID = 5;
   localparam int DLY = 4;
   localparam int LW = $clog2(BW / 8) + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rq_valid = 0, rs_valid = 0, dir_ready = 0;
   logic [1:0] rq_kind = 0, rs_kind = 0;
   logic [AW-1:0] rq_paddr = 0, rq_laddr = 0;
   logic [BW-1:0] rq_data = 0, rs_data = 0;
   logic [LW-1:0] rq_len = 0;
   logic rq_ready, rs_ready, dir_valid, dir_is_wr, seq_data_vld, seq_ack_vld, err_flag;
   logic [AW-1:0] dir_paddr, dir_laddr, seq_laddr;
   logic [IW-1:0] dir_rqid;
   logic [BW-1:0] dir_data, seq_data;
   logic [LW-1:0] dir_len;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dma_req_bridge #(.ADDR_W(AW), .BLK_W(BW), .ID_W(IW), .REQ_ID(RID), .ISSUE_DLY(DLY)) u0 (
      .clk(clk), .rst_n(rst_n),
      .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_kind(rq_kind),
      .rq_paddr(rq_paddr), .rq_laddr(rq_laddr), .rq_data(rq_data), .rq_len(rq_len),
      .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_kind(rs_kind), .rs_data(rs_data),
      .dir_valid(dir_valid), .dir_ready(dir_ready), .dir_is_wr(dir_is_wr),
      .dir_paddr(dir_paddr), .dir_laddr(dir_laddr), .dir_rqid(dir_rqid),
      .dir_data(dir_data), .dir_len(dir_len),
      .seq_data_vld(seq_data_vld), .seq_ack_vld(seq_ack_vld),
      .seq_laddr(seq_laddr), .seq_data(seq_data), .err_flag(err_flag)
   );

   // stimulus table: request code, addresses, block, length, returned block
   localparam int NV = 4;
   localparam logic [1:0]    V_KIND [NV] = '{2'b01, 2'b10, 2'b10, 2'b01};
   localparam logic [AW-1:0] V_PA   [NV] = '{16'h1234, 16'h0A5C, 16'hFFFF, 16'h0040};
   localparam logic [AW-1:0] V_LA   [NV] = '{16'h1200, 16'h0A40, 16'hFFC0, 16'h0040};
   localparam logic [BW-1:0] V_DAT  [NV] = '{32'hDEADBEEF, 32'h01234567, 32'hFFFFFFFF, 32'h0};
   localparam logic [LW-1:0] V_LEN  [NV] = '{3'd4, 3'd1, 3'd4, 3'd2};
   localparam logic [BW-1:0] V_RET  [NV] = '{32'hCAFEF00D, 32'h0, 32'h0, 32'h5A5AA5A5};

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic do_reset();
      rst_n = 0;
      rq_valid = 0; rs_valid = 0; dir_ready = 0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1;
      tick();
   endtask

   // drive the request channel for one edge; returns just after the accepting edge
   task automatic send_req(input logic [1:0] k, input logic [AW-1:0] pa, input logic [AW-1:0] la,
                           input logic [BW-1:0] d, input logic [LW-1:0] ln);
      rq_valid = 1; rq_kind = k; rq_paddr = pa; rq_laddr = la; rq_data = d; rq_len = ln;
      tick();
      rq_valid = 0;
   endtask

   // wait the issue delay, checking dir_valid timing (R4)
   task automatic wait_issue(input string tag);
      chk(dir_valid == 0, {"R4 early ", tag}, dir_valid, 0);
      for (int k = 1; k <= DLY; k++) begin
         tick();
         if (k < DLY) chk(dir_valid == 0, {"R4 early ", tag}, dir_valid, 0);
      end
      chk(dir_valid == 1, {"R4 on time ", tag}, dir_valid, 1);
   endtask

   task automatic take_dir();
      dir_ready = 1;
      tick();
      dir_ready = 0;
      chk(dir_valid == 0, "R5 drop after take", dir_valid, 0);
      chk(rs_ready == 1, "R9 open after take", rs_ready, 1);
   endtask

   task automatic send_rsp(input logic [1:0] k, input logic [BW-1:0] d);
      rs_valid = 1; rs_kind = k; rs_data = d;
      tick();
      rs_valid = 0;
   endtask

   task automatic run_vec(input int i);
      logic wr;
      wr = (V_KIND[i] == 2'b10);
      send_req(V_KIND[i], V_PA[i], V_LA[i], V_DAT[i], V_LEN[i]);
      chk(rq_ready == 0, "R6 busy", rq_ready, 0);
      wait_issue($sformatf("vec%0d", i));
      if (wr) chk(dir_is_wr == 1, "R3 write type", dir_is_wr, 1);
      else    chk(dir_is_wr == 0, "R2 read type", dir_is_wr, 0);
      chk(dir_paddr == V_PA[i], "R2 paddr", dir_paddr, V_PA[i]);
      chk(dir_laddr == V_LA[i], "R2 laddr", dir_laddr, V_LA[i]);
      chk(dir_data == V_DAT[i], "R3 data", dir_data, V_DAT[i]);
      chk(dir_len == V_LEN[i], "R3 len", dir_len, V_LEN[i]);
      chk(dir_rqid == IW'(RID), "R2 rqid", dir_rqid, RID);
      tick();
      chk(dir_valid == 1 && dir_laddr == V_LA[i], "R5 hold", dir_laddr, V_LA[i]);
      chk(rs_ready == 0, "R9 closed while pending", rs_ready, 0);
      take_dir();
      chk(rq_ready == 0, "R6 still busy", rq_ready, 0);
      if (wr) begin
         send_rsp(2'b10, '0);
         chk(seq_ack_vld == 1 && seq_data_vld == 0, "R8 ack strobe", seq_ack_vld, 1);
         chk(seq_laddr == V_LA[i], "R8 laddr", seq_laddr, V_LA[i]);
      end else begin
         send_rsp(2'b01, V_RET[i]);
         chk(seq_data_vld == 1 && seq_ack_vld == 0, "R7 data strobe", seq_data_vld, 1);
         chk(seq_data == V_RET[i], "R7 data", seq_data, V_RET[i]);
         chk(seq_laddr == V_LA[i], "R7 laddr", seq_laddr, V_LA[i]);
      end
      chk(rq_ready == 1, "R6 free again", rq_ready, 1);
      tick();
      chk(seq_data_vld == 0 && seq_ack_vld == 0, "R7 R8 one cycle", {seq_data_vld, seq_ack_vld}, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk(rq_ready == 1, "R1 rq_ready", rq_ready, 1);
      chk(dir_valid == 0, "R1 dir_valid", dir_valid, 0);
      chk(seq_data_vld == 0 && seq_ack_vld == 0, "R1 strobes", {seq_data_vld, seq_ack_vld}, 0);
      chk(err_flag == 0, "R1 err", err_flag, 0);

      for (int i = 0; i < NV; i++) run_vec(i);
      chk(err_flag == 0, "R11 no error on clean traffic", err_flag, 0);

      // R6: store held on the channel while a read is in flight
      send_req(2'b01, 16'h2000, 16'h2000, 32'h11112222, 3'd4);
      rq_valid = 1; rq_kind = 2'b10; rq_paddr = 16'h3008; rq_laddr = 16'h3000;
      rq_data = 32'h77778888; rq_len = 3'd3;
      wait_issue("stall");
      chk(dir_is_wr == 0 && dir_laddr == 16'h2000, "R6 read not replaced", dir_laddr, 16'h2000);
      chk(rq_ready == 0, "R6 held store stalled", rq_ready, 0);
      take_dir();
      send_rsp(2'b01, 32'h9999AAAA);
      chk(seq_data_vld == 1 && seq_data == 32'h9999AAAA, "R7 data in stall test", seq_data, 32'h9999AAAA);
      chk(rq_ready == 1, "R6 ready for held store", rq_ready, 1);
      tick();
      rq_valid = 0;
      chk(rq_ready == 0, "R6 held store taken", rq_ready, 0);
      wait_issue("held");
      chk(dir_is_wr == 1 && dir_laddr == 16'h3000, "R6 held store issued", dir_laddr, 16'h3000);
      take_dir();

      // R11: data response while a write is pending
      send_rsp(2'b01, 32'hBAD0BAD0);
      chk(seq_data_vld == 0, "R11 no data strobe in write", seq_data_vld, 0);
      chk(err_flag == 1, "R11 err on wrong response", err_flag, 1);
      chk(rq_ready == 0, "R11 write still pending", rq_ready, 0);
      send_rsp(2'b10, '0);
      chk(seq_ack_vld == 1 && seq_laddr == 16'h3000, "R8 ack after bad rsp", seq_laddr, 16'h3000);
      tick();
      chk(err_flag == 1, "R12 sticky", err_flag, 1);

      // R10: illegal request code
      do_reset();
      send_req(2'b11, 16'h4444, 16'h4440, 32'h1, 3'd1);
      chk(err_flag == 1, "R10 err on bad request", err_flag, 1);
      chk(rq_ready == 1, "R10 stays idle", rq_ready, 1);
      for (int k = 0; k <= DLY + 1; k++) begin
         chk(dir_valid == 0, "R10 no message", dir_valid, 0);
         tick();
      end

      // R11: stray responses while idle
      do_reset();
      send_rsp(2'b01, 32'h12121212);
      chk(seq_data_vld == 0, "R11 no strobe when idle", seq_data_vld, 0);
      chk(err_flag == 1, "R11 err idle data", err_flag, 1);
      do_reset();
      send_rsp(2'b00, '0);
      chk(err_flag == 1 && seq_ack_vld == 0, "R11 bad response code", err_flag, 1);
      // R12: error survives good traffic, cleared only by reset
      run_vec(1);
      chk(err_flag == 1, "R12 sticky through traffic", err_flag, 1);
      do_reset();
      chk(err_flag == 0, "R12 cleared by reset", err_flag, 0);

      done = 1;
      report();
   end
endmodule